// File: doc/BRIEF.md
# DDS Control Word Loader

This block is the host-facing register front end of a direct digital synthesizer. A host writes a 40-bit control word: a 32-bit frequency tuning word plus an 8-bit control byte that carries a 5-bit phase offset, a power-down flag and a 2-bit mode field. The word can arrive in two ways. In parallel form it comes as five bytes on an 8-bit data bus. In serial form it comes as forty single bits on the top pin of that same bus. In both forms each item is marked by a rising edge of a word clock.

Incoming data fills a shadow register. The shadow is copied into the active register, whose fields drive the outputs, only when the host raises an update strobe. Word clock and update strobe are asynchronous to the system clock. Each passes through a synchronizer with rising-edge detection, and the whole active word changes on one system-clock edge. The block powers up in parallel form. A particular control byte, applied by an update, switches it to serial form. After that, only reset brings it back.

Top module: `dds_word_loader`

## Requirements
- R1: While `rst` is high at a rising `sys_clk` edge, the active word and the shadow word clear. After reset, `tune_word`, `phase_word` and `power_down` read zero and `serial_active` reads 0 (parallel form).
- R2: In parallel form, successive word-clock rising edges load byte 0 = control byte, then the frequency bytes from most to least significant (bits 31:24, 23:16, 15:8, 7:0). The control byte places the phase offset in bits 7:3, power-down in bit 2 and the mode field in bits 1:0.
- R3: In parallel form, word-clock edges after the fifth byte and before the next update or reset leave the shadow unchanged.
- R4: In serial form, each word-clock rising edge takes `data_in[7]` as the next bit, least significant first. Bits 0..31 are frequency bits 0..31 and bits 32..39 are control bits 0..7. `data_in[6:0]` is ignored.
- R5: In serial form, bits after the fortieth and before the next update or reset are ignored. They do not wrap onto bit 0.
- R6: The outputs change only on an update. Loading without an update leaves every output unchanged. An update copies the whole shadow word into the active word at once.
- R7: An update returns the byte pointer and the bit counter to the start, so the next load begins with the control byte (parallel form) or bit 0 (serial form). Shadow bits that are not rewritten keep their values.
- R8: An update whose shadow control byte has mode field bits 1:0 = 2'b11 switches the block into serial form, and `serial_active` goes to 1.
- R9: Once in serial form, the block stays there whatever is loaded or updated. Only reset returns it to parallel form.
- R10: An input edge seen by `sys_clk` edge k takes effect at edge k+2 (two synchronizer flops). An update strobe raised just before edge k leaves the outputs unchanged after edge k+1 and updates them after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| word_clk | input | 1 | Word clock from the host; each rising edge marks a byte or bit |
| upd_strobe | input | 1 | Update strobe; a rising edge applies the shadow word |
| data_in | input | 8 | Parallel byte; bit 7 is the serial data pin |
| tune_word | output | 32 | Active frequency tuning word |
| phase_word | output | 5 | Active phase offset |
| power_down | output | 1 | Active power-down flag |
| serial_active | output | 1 | 1 when the block is in serial load form |

## Verification
Every host input passes through two synchronizer flops and an edge detector, so a stimulus first seen by one system-clock edge affects the shadow, the active word or the mode two edges later. The bench keeps each word-clock and strobe level for three system cycles and waits three more before it samples on a falling edge, which keeps every check clear of the k+2 edge. One directed test raises the strobe and samples after exactly one and two further edges, to confirm the outputs hold and then change on the predicted edge.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

    localparam int FREQ_W      = 32;
    localparam int CTRL_W      = 8;
    localparam int BUS_W       = 8;
    localparam int SYNC_STAGES = 2;
    localparam int WORD_W      = FREQ_W + CTRL_W;
    localparam int NBYTES      = WORD_W / BUS_W;
    localparam int PTR_W       = $clog2(NBYTES + 1);
    localparam int CNT_W       = $clog2(WORD_W + 1);
    localparam int SER_PIN     = BUS_W - 1;

    localparam logic [1:0] SERIAL_CODE = 2'b11;

    typedef enum logic {
        LD_PARALLEL = 1'b0,
        LD_SERIAL   = 1'b1
    } ld_mode_e;

    typedef struct packed {
        logic [4:0] phase;
        logic       pdown;
        logic [1:0] mode;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [FREQ_W-1:0] freq;
    } dds_word_t;

    // Parallel byte p lands in slice NBYTES-1-p: control first, then freq MSB..LSB.
    function automatic logic [WORD_W-1:0] put_byte(
        input logic [WORD_W-1:0] w,
        input logic [PTR_W-1:0]  p,
        input logic [BUS_W-1:0]  b
    );
        logic [WORD_W-1:0] r;
        r = w;
        for (int k = 0; k < NBYTES; k++) begin
            if (k == NBYTES - 1 - int'(p)) begin
                r[k*BUS_W +: BUS_W] = b;
            end
        end
        return r;
    endfunction

    function automatic logic is_serial_cmd(input ctrl_t c);
        return c.mode == SERIAL_CODE;
    endfunction

endpackage

// File: rtl/dds_ldr_sync.sv
module dds_ldr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], async_in};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R10: an edge yields exactly one single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/dds_ldr_shadow.sv
module dds_ldr_shadow
    import dds_ldr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ld_mode_e         mode,
    input  logic             stb,
    input  logic             clr,
    input  logic [BUS_W-1:0] din,
    output dds_word_t        shadow
);
    logic [WORD_W-1:0] sh_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              par_room;
    logic              ser_room;

    assign par_room = ptr_q < PTR_W'(NBYTES);
    assign ser_room = cnt_q < CNT_W'(WORD_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (stb) begin
            if (mode == LD_SERIAL) begin
                if (ser_room) begin
                    sh_q[cnt_q] <= din[SER_PIN];
                    cnt_q       <= cnt_q + 1'b1;
                end
            end else if (par_room) begin
                sh_q  <= put_byte(sh_q, ptr_q, din);
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign shadow = dds_word_t'(sh_q);

    // R3: byte pointer never passes the word length
    a_r3_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= PTR_W'(NBYTES));
    // R3: a sixth parallel byte leaves the shadow alone
    a_r3_extra_byte: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr && mode == LD_PARALLEL && !par_room) |=> $stable(sh_q));
    // R5: bit counter never passes forty, extra serial bits are dropped
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(WORD_W));
    a_r5_extra_bit: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr && mode == LD_SERIAL && !ser_room) |=> $stable(sh_q));
    // R7: an update rewinds both load positions
    a_r7_rewind: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr_q == '0 && cnt_q == '0));

endmodule

// File: rtl/dds_ldr_active.sv
module dds_ldr_active
    import dds_ldr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      upd,
    input  dds_word_t shadow,
    output dds_word_t act,
    output ld_mode_e  mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= '0;
            mode <= LD_PARALLEL;
        end else if (upd) begin
            act <= shadow;
            if (is_serial_cmd(shadow.ctrl)) begin
                mode <= LD_SERIAL;
            end
        end
    end

    // R1: reset clears the active word and selects parallel form
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (act == '0 && mode == LD_PARALLEL));
    // R6: without an update the active word holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(act));
    // R6: an update takes the entire shadow word in one edge
    a_r6_copy: assert property (@(posedge clk) disable iff (rst)
        upd |=> act == $past(shadow));
    // R9: serial form is sticky until reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        mode == LD_SERIAL |=> mode == LD_SERIAL);
    // R8: the serial command switches form
    a_r8_enter: assert property (@(posedge clk) disable iff (rst)
        (upd && is_serial_cmd(shadow.ctrl)) |=> mode == LD_SERIAL);

endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
    import dds_ldr_pkg::*;
(
    input  logic                sys_clk,
    input  logic                rst,
    input  logic                word_clk,
    input  logic                upd_strobe,
    input  logic [BUS_W-1:0]    data_in,
    output logic [FREQ_W-1:0]   tune_word,
    output logic [4:0]          phase_word,
    output logic                power_down,
    output logic                serial_active
);
    logic      wclk_rise;
    logic      upd_rise;
    ld_mode_e  mode;
    dds_word_t shadow;
    dds_word_t act;

    dds_ldr_sync #(.STAGES(SYNC_STAGES)) u_wclk_sync (
        .clk      (sys_clk),
        .rst      (rst),
        .async_in (word_clk),
        .rise     (wclk_rise)
    );

    dds_ldr_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk      (sys_clk),
        .rst      (rst),
        .async_in (upd_strobe),
        .rise     (upd_rise)
    );

    dds_ldr_shadow u_shadow (
        .clk    (sys_clk),
        .rst    (rst),
        .mode   (mode),
        .stb    (wclk_rise),
        .clr    (upd_rise),
        .din    (data_in),
        .shadow (shadow)
    );

    dds_ldr_active u_active (
        .clk    (sys_clk),
        .rst    (rst),
        .upd    (upd_rise),
        .shadow (shadow),
        .act    (act),
        .mode   (mode)
    );

    assign tune_word     = act.freq;
    assign phase_word    = act.ctrl.phase;
    assign power_down    = act.ctrl.pdown;
    assign serial_active = (mode == LD_SERIAL);

endmodule

// File: tb/dds_word_loader_test.sv
module dds_word_loader_test;
    localparam int CLK_PERIOD = 10;

    logic        sys_clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_clk = 1'b0;
    logic        upd_strobe = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [31:0] tune_word;
    logic [4:0]  phase_word;
    logic        power_down;
    logic        serial_active;

    int n_checks = 0;
    int n_fails  = 0;

    dds_word_loader uut (
        .sys_clk       (sys_clk),
        .rst           (rst),
        .word_clk      (word_clk),
        .upd_strobe    (upd_strobe),
        .data_in       (data_in),
        .tune_word     (tune_word),
        .phase_word    (phase_word),
        .power_down    (power_down),
        .serial_active (serial_active)
    );

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    localparam int NVEC = 4;
    localparam logic [39:0] VEC [NVEC] = '{
        {8'hA4, 32'h12345678},
        {8'h01, 32'hFFFFFFFF},
        {8'hF8, 32'h00000001},
        {8'h5A, 32'h80000000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] obs();
        return {26'b0, phase_word, power_down, tune_word};
    endfunction

    function automatic logic [63:0] want(input logic [39:0] w);
        return {26'b0, w[39:34], w[31:0]};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge sys_clk) data_in = b;
        repeat (2) @(negedge sys_clk);
        word_clk = 1'b1;
        repeat (3) @(negedge sys_clk);
        word_clk = 1'b0;
        repeat (3) @(negedge sys_clk);
    endtask

    task automatic strobe();
        @(negedge sys_clk) upd_strobe = 1'b1;
        repeat (3) @(negedge sys_clk);
        upd_strobe = 1'b0;
        repeat (3) @(negedge sys_clk);
    endtask

    task automatic load_par(input logic [39:0] w);
        send_byte(w[39:32]);
        send_byte(w[31:24]);
        send_byte(w[23:16]);
        send_byte(w[15:8]);
        send_byte(w[7:0]);
    endtask

    task automatic load_ser(input logic [39:0] w);
        for (int i = 0; i < 40; i++) begin
            send_byte({w[i], (i % 2 == 0) ? 7'h55 : 7'h2A});
        end
    endtask

    task automatic do_reset();
        @(negedge sys_clk) rst = 1'b1;
        repeat (3) @(negedge sys_clk);
        rst = 1'b0;
        repeat (2) @(negedge sys_clk);
    endtask

    initial begin
        repeat (200000) @(posedge sys_clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [39:0] prev;
        do_reset();
        // R1: reset state
        check("R1 word after reset", obs(), 64'h0);
        check("R1 parallel form after reset", {63'b0, serial_active}, 64'h0);
        prev = 40'h0;

        // Vector table: R2 ordering, R6 no change before the update
        for (int v = 0; v < NVEC; v++) begin
            load_par(VEC[v]);
            check("R6 no update yet", obs(), want(prev));
            strobe();
            check("R2 parallel load", obs(), want(VEC[v]));
            prev = VEC[v];
        end

        // R3: extra bytes after the fifth are dropped
        load_par({8'h28, 32'hCAFE0123});
        send_byte(8'hEE);
        send_byte(8'h77);
        strobe();
        check("R3 extra bytes ignored", obs(), want({8'h28, 32'hCAFE0123}));

        // R7: pointer rewinds; untouched shadow bytes keep old values
        send_byte(8'h10);
        send_byte(8'hAB);
        strobe();
        check("R7 partial reload", obs(), want({8'h10, 32'hABFE0123}));

        // R10: update latency, two synchronizer flops
        load_par({8'hC0, 32'h0F0F0F0F});
        @(negedge sys_clk) upd_strobe = 1'b1;
        repeat (2) @(negedge sys_clk);
        check("R10 unchanged after edge k+1", obs(), want({8'h10, 32'hABFE0123}));
        @(negedge sys_clk);
        check("R10 updated after edge k+2", obs(), want({8'hC0, 32'h0F0F0F0F}));
        repeat (2) @(negedge sys_clk);
        upd_strobe = 1'b0;
        repeat (3) @(negedge sys_clk);

        // R8: serial command enters serial form
        check("R8 still parallel", {63'b0, serial_active}, 64'h0);
        load_par({8'h03, 32'h0BADF00D});
        strobe();
        check("R8 serial form entered", {63'b0, serial_active}, 64'h1);
        check("R8 command word applied", obs(), want({8'h03, 32'h0BADF00D}));

        // R4: serial LSB first on data_in[7]; R6 no change before update
        load_ser({8'h8C, 32'hDEADBEEF});
        check("R6 serial no update yet", obs(), want({8'h03, 32'h0BADF00D}));
        strobe();
        check("R4 serial load", obs(), want({8'h8C, 32'hDEADBEEF}));
        check("R9 stays serial", {63'b0, serial_active}, 64'h1);

        // R5: bits past forty do not wrap onto bit 0
        load_ser({8'h20, 32'h00000000});
        send_byte(8'hFF);
        send_byte(8'hFF);
        send_byte(8'hFF);
        strobe();
        check("R5 extra bits ignored", obs(), want({8'h20, 32'h00000000}));

        // R9: parallel-looking bytes do not leave serial form
        send_byte(8'h00);
        strobe();
        check("R9 serial kept after loads", {63'b0, serial_active}, 64'h1);
        check("R7 serial restart at bit 0", obs(), want({8'h20, 32'h00000000}));

        // R9 / R1: reset returns parallel form and clears the word
        do_reset();
        check("R9 reset exits serial", {63'b0, serial_active}, 64'h0);
        check("R1 word cleared by reset", obs(), 64'h0);
        load_par({8'h6C, 32'h13579BDF});
        strobe();
        check("R2 parallel after reset", obs(), want({8'h6C, 32'h13579BDF}));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule